// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds and raises an alarm when that count reaches a programmed match value. A prescaler counts system clock cycles and gives a one-cycle enable once per second. Each enable advances the seconds count by one, and the count wraps at 2^32. Software reaches the block through a simple 32-bit register bus with synchronous strobes. It can load a new count, program a match value, mask the alarm and clear it.

The alarm is a sticky raw flag. It is set when a tick brings the count to the match value. It is also set straight away when a write to the match or load register makes the count and the match value equal. A one-bit mask gates the raw flag onto a single level interrupt line. A fixed table of eight identification bytes sits at the top of the 4 KB register window.

A read strobe captures read data on the clock edge where it is sampled, so the data is valid the cycle after the strobe. A write takes effect on the clock edge where it is sampled.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the count, match value, load value, mask and raw flag all read 0, and `irq` is low.
- R2: The count advances by 1 once every CLK_HZ system clocks and wraps from 0xFFFFFFFF to 0. The count is read at offset 0x00.
- R3: A write to offset 0x08 replaces the count with the written value and restarts the one-second prescaler. Reading 0x08 returns the last value written there.
- R4: The match value at offset 0x04 is read/write and holds all 32 bits.
- R5: The raw flag (bit 0 of offset 0x14) is set when a tick brings the count to the match value.
- R6: The raw flag is set on the write edge when a write to offset 0x04 or to offset 0x08 makes the count equal to the match value.
- R7: A write to offset 0x1C clears the raw flag when write-data bit 0 is 1; with bit 0 at 0 the flag is unchanged. A read of 0x1C returns 0.
- R8: Only bit 0 of a write to the mask at offset 0x10 is kept. `irq` and the masked status at offset 0x18 equal raw flag AND mask, and follow a mask change on the edge of the write.
- R9: Offset 0x0C always reads 1, and writes to it have no effect.
- R10: The eight words at offsets 0xFE0 to 0xFFC read, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low byte, with all upper bits 0.
- R11: Writes to offsets 0x00, 0x14 and 0x18 are ignored. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; data is valid the following cycle |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: raw alarm flag AND mask |

## Verification
The embedded assertions check the following on every cycle:
- The prescaler never gives two enables in a row, and a restart always suppresses the next enable.
- The count either holds, steps by exactly one on an enable, or takes the loaded value.
- The raw flag drops after a clear with bit 0 set, unless a match event happens in the same cycle.

Only the bench's scenarios can show the following:
- The one-second period and wrap-around of the count.
- That a write making the count equal to the match value raises the alarm immediately, not one second late.
- The identification table contents.
- That writes to read-only registers leave state intact.

// File: rtl/rtc_pkg.sv
// Package: shared register offsets and identification table for the
// seconds-counter alarm block. Assumes a 12-bit byte address, word aligned.
package rtc_pkg;

    localparam int          RTC_AW       = 12;
    localparam int          RTC_DW       = 32;

    localparam logic [11:0] OFF_COUNT    = 12'h000;
    localparam logic [11:0] OFF_MATCH    = 12'h004;
    localparam logic [11:0] OFF_LOAD     = 12'h008;
    localparam logic [11:0] OFF_CTRL     = 12'h00C;
    localparam logic [11:0] OFF_MASK     = 12'h010;
    localparam logic [11:0] OFF_RAW      = 12'h014;
    localparam logic [11:0] OFF_MASKED   = 12'h018;
    localparam logic [11:0] OFF_CLEAR    = 12'h01C;
    localparam logic [6:0]  ID_WIN_TOP   = 7'h7F;   // addr[11:5] of 0xFE0..0xFFF

    // Identification byte for word index 0..7 of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h31;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
// Module: one-second enable generator.
// Counts system clocks and pulses tick for one cycle every CLK_HZ cycles.
// A restart request returns the phase to zero so that a full period
// elapses before the next tick. Assumes CLK_HZ >= 1.
module rtc_tick_gen #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int              CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] phase;

    assign tick = (phase == LAST) && !restart;

    // Advance the phase counter, wrapping at the end of each second.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CLK_HZ > 1) && tick |=> !tick);

    // R3
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CLK_HZ > 1) && restart |=> !tick);

endmodule

// File: rtl/rtc_sec_core.sv
// Module: seconds count, match value, load value and sticky alarm flag.
// Assumes at most one of load_we / match_we / clr_we is high per cycle.
// The alarm is raised on any event (tick, load, match write) whose
// resulting count equals the resulting match value.
module rtc_sec_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load_we,
    input  logic          match_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count,
    output logic [DW-1:0] match_val,
    output logic [DW-1:0] load_val,
    output logic          raw
);

    logic [DW-1:0] count_nxt;
    logic [DW-1:0] match_nxt;
    logic          evt;

    // Next count and match value as seen after this edge.
    always_comb begin
        count_nxt = count;
        if (load_we)   count_nxt = wdata;
        else if (tick) count_nxt = count + 1'b1;
        match_nxt = match_we ? wdata : match_val;
        evt       = load_we || match_we || tick;
    end

    // Register count, match and load values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            match_val <= '0;
            load_val  <= '0;
        end else begin
            count     <= count_nxt;
            match_val <= match_nxt;
            if (load_we) load_val <= wdata;
        end
    end

    // Sticky alarm flag: set on a matching event, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (evt && (count_nxt == match_nxt)) begin
            raw <= 1'b1;
        end else if (clr_we && wdata[0]) begin
            raw <= 1'b0;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load_we |=> count == $past(count) + 1'b1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load_we |=> $stable(count));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(wdata)) && (load_val == $past(wdata)));

    // R7
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && wdata[0] && !tick |=> !raw);

endmodule

// File: rtl/rtc_alarm_timer.sv
// Module: top of the seconds-counter alarm peripheral.
// Decodes the register bus, keeps the one-bit interrupt mask, builds the
// registered read data and drives the level interrupt. Assumes the bus
// never asserts read and write in the same cycle, and word-aligned addresses.
module rtc_alarm_timer #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [rtc_pkg::RTC_AW-1:0] bus_addr,
    input  logic [rtc_pkg::RTC_DW-1:0] bus_wdata,
    output logic [rtc_pkg::RTC_DW-1:0] bus_rdata,
    output logic                       irq
);
    import rtc_pkg::*;

    localparam int DW = RTC_DW;

    logic [11:0]   word_addr;
    logic          tick;
    logic          load_we, match_we, clr_we, mask_we;
    logic [DW-1:0] count, match_val, load_val;
    logic          raw, mask, masked;

    assign word_addr = {bus_addr[11:2], 2'b00};
    assign load_we   = bus_wr && (word_addr == OFF_LOAD);
    assign match_we  = bus_wr && (word_addr == OFF_MATCH);
    assign clr_we    = bus_wr && (word_addr == OFF_CLEAR);
    assign mask_we   = bus_wr && (word_addr == OFF_MASK);
    assign masked    = raw & mask;
    assign irq       = masked;

    rtc_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_we),
        .tick    (tick)
    );

    rtc_sec_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_we   (load_we),
        .match_we  (match_we),
        .clr_we    (clr_we),
        .wdata     (bus_wdata),
        .count     (count),
        .match_val (match_val),
        .load_val  (load_val),
        .raw       (raw)
    );

    // Interrupt mask: keep bit 0 of a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 1'b0;
        else if (mask_we) mask <= bus_wdata[0];
    end

    // Registered read data, selected by offset on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr[11:5] == ID_WIN_TOP) begin
                bus_rdata <= {{(DW-8){1'b0}}, id_byte(bus_addr[4:2])};
            end else begin
                case (word_addr)
                    OFF_COUNT:  bus_rdata <= count;
                    OFF_MATCH:  bus_rdata <= match_val;
                    OFF_LOAD:   bus_rdata <= load_val;
                    OFF_CTRL:   bus_rdata <= DW'(1);
                    OFF_MASK:   bus_rdata <= DW'(mask);
                    OFF_RAW:    bus_rdata <= DW'(raw);
                    OFF_MASKED: bus_rdata <= DW'(masked);
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

    // R8
    mask_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we && !bus_wdata[0] |=> !irq);

    // R1
    reset_irq_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/rtc_alarm_timer_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// the registered read data the cycle after each read strobe.
module rtc_alarm_timer_tb;

    localparam int CLK_HZ = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rd_seen = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    exp_t        q[$];
    exp_t        mon_e;

    always #5 clk = ~clk;

    rtc_alarm_timer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: one comparison per sampled read strobe.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q.size() == 0) begin
                check("monitor queue empty", 32'h1, 32'h0);
            end else begin
                mon_e = q.pop_front();
                check(mon_e.tag, bus_rdata, mon_e.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(12'h000, 32'h0, "R1 count");
        rd(12'h004, 32'h0, "R1 match");
        rd(12'h008, 32'h0, "R1 load");
        rd(12'h010, 32'h0, "R1 mask");
        rd(12'h014, 32'h0, "R1 raw");
        rd(12'h018, 32'h0, "R1 masked");
        // R9 control
        rd(12'h00C, 32'h1, "R9 ctrl");
        wr(12'h00C, 32'h0);
        rd(12'h00C, 32'h1, "R9 ctrl after write");
        // R10 ID table
        rd(12'hFE0, 32'h31, "R10 id0");
        rd(12'hFE4, 32'h10, "R10 id1");
        rd(12'hFE8, 32'h14, "R10 id2");
        rd(12'hFEC, 32'h00, "R10 id3");
        rd(12'hFF0, 32'h0D, "R10 id4");
        rd(12'hFF4, 32'hF0, "R10 id5");
        rd(12'hFF8, 32'h05, "R10 id6");
        rd(12'hFFC, 32'hB1, "R10 id7");
        // R11 unmapped, R7 clear reads 0
        rd(12'h020, 32'h0, "R11 unmapped 0x20");
        rd(12'h800, 32'h0, "R11 unmapped 0x800");
        rd(12'h01C, 32'h0, "R7 clear reads 0");
        // R4 match, R3 load
        wr(12'h004, 32'h0000_0100);
        rd(12'h004, 32'h0000_0100, "R4 match readback");
        wr(12'h008, 32'h0000_0050);
        rd(12'h000, 32'h0000_0050, "R3 count after load");
        rd(12'h008, 32'h0000_0050, "R3 load readback");
        wr(12'h000, 32'h0000_0999);
        rd(12'h000, 32'h0000_0050, "R11 count write ignored");
        idle(12);
        rd(12'h000, 32'h0000_0051, "R2 count after one second");
        // R2 wrap
        wr(12'h008, 32'hFFFF_FFFF);
        idle(12);
        rd(12'h000, 32'h0000_0000, "R2 wrap to zero");
        // R5 alarm by tick
        wr(12'h004, 32'h0000_0200);
        wr(12'h008, 32'h0000_01FF);
        rd(12'h014, 32'h0, "R5 raw before tick");
        idle(12);
        rd(12'h014, 32'h1, "R5 raw after tick match");
        check("R8 irq masked off", {31'b0, irq}, 32'h0);
        rd(12'h018, 32'h0, "R8 masked status off");
        wr(12'h010, 32'hFFFF_FFFF);
        check("R8 irq follows mask", {31'b0, irq}, 32'h1);
        rd(12'h010, 32'h1, "R8 mask bit0 only");
        rd(12'h018, 32'h1, "R8 masked status on");
        wr(12'h014, 32'h0);
        wr(12'h018, 32'h0);
        rd(12'h014, 32'h1, "R11 raw write ignored");
        wr(12'h01C, 32'hFFFF_FFFE);
        rd(12'h014, 32'h1, "R7 clear with bit0 low");
        wr(12'h01C, 32'h1);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);
        rd(12'h014, 32'h0, "R7 raw after clear");
        // R6 immediate by load
        wr(12'h008, 32'h0000_0200);
        check("R6 irq on load equal", {31'b0, irq}, 32'h1);
        wr(12'h01C, 32'h1);
        check("R7 irq cleared again", {31'b0, irq}, 32'h0);
        // R6 immediate by match
        wr(12'h008, 32'h0000_0300);
        check("R6 irq before match write", {31'b0, irq}, 32'h0);
        wr(12'h004, 32'h0000_0300);
        check("R6 irq on match equal", {31'b0, irq}, 32'h1);
        wr(12'h010, 32'h0000_0002);
        check("R8 irq drops with mask", {31'b0, irq}, 32'h0);
        rd(12'h010, 32'h0, "R8 mask write bit0 zero");
        rd(12'h014, 32'h1, "R8 raw kept under mask");
        idle(3);
        summary();
    end

endmodule